// File: doc/BRIEF.md
# Single-Clock Flip-Flop Emulator

This block reproduces the behaviour of a storage element that has its own user clock, a level enable and asynchronous set, clear or reset inputs. It does so using only registers on one fast global sampling clock. Every input is sampled on each global tick. A user-clock edge is found by comparing the current sample of the user clock with the sample from the previous tick. The emulated output is then formed from delayed copies of the data and of the output itself, plus the asynchronous controls.

The storage style is chosen by a parameter:

- an edge-triggered register, whose active clock polarity is selectable;
- a level-sensitive latch;
- a plain register that needs no conversion.

A second parameter adds one of three asynchronous overlays:

- none;
- a single reset that forces a parameter value;
- per-bit set and clear.

Each asynchronous control is stretched by one tick, so that a pulse is never shorter than a sample. The output is combinational from the stored state and the current controls. An asserted control therefore shows in the same tick it appears.

A design that mixes several user clocks can be placed on one global clock this way. All user clocks and controls are then ordinary sampled data signals.

Top module: `ffemu_top`

## Requirements
- R1: While `rst_n` is low on a `gclk` edge, the stored output and stored data copies load `INIT_VAL`. The user-clock copy loads the active clock level. Each control copy loads its inactive level. In the first tick after reset, with the user clock still at its active level and all controls inactive, `q` equals `INIT_VAL`.
- R2: An active user-clock edge is seen when the previous and current samples of `uclk` are (0,1) with `CLK_POL`=1, or (1,0) with `CLK_POL`=0. Any other pair is no edge.
- R3: In edge mode, a tick with an active edge presents the `d` sampled one tick earlier. A tick without an edge presents the previous tick's `q`.
- R4: In latch mode, `q` follows the current `d` while the stretched enable is active. Otherwise it holds the previous tick's `q`.
- R5: Each asynchronous control counts as active in a tick if it is active now or was active in the previous tick. Its effect therefore lasts one tick beyond its release.
- R6: In set/clear mode, `q` is the stored value ORed with the stretched set bits, then ANDed with the inverse of the stretched clear bits. A bit that is both set and cleared reads 0.
- R7: In reset mode, `q` equals `RST_VAL` whenever the stretched reset is active.
- R8: In plain mode, `q` equals `d` delayed by one tick. `uclk`, `en`, `arst`, `set` and `clr` have no effect on it.
- R9: Each control has its own polarity parameter (1 = active high, 0 = active low). An active-low control is active when either its current sample or its previous sample is 0.
- R10: An asynchronous control that becomes active changes `q` in the same tick it is sampled, with no register stage in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| gclk | input | 1 | Global sampling clock |
| rst_n | input | 1 | Synchronous active-low initialisation |
| uclk | input | 1 | Emulated user clock, sampled as data |
| d | input | WIDTH | Data input of the emulated element |
| en | input | 1 | Latch enable (latch mode) |
| arst | input | 1 | Asynchronous reset (reset overlay) |
| set | input | WIDTH | Per-bit asynchronous set (set/clear overlay) |
| clr | input | WIDTH | Per-bit asynchronous clear (set/clear overlay) |
| q | output | WIDTH | Emulated output |

## Verification
The embedded properties check the following on every tick:

- an edge only appears on a real change of `uclk` towards the active level;
- each stretched control still covers its previous-tick assertion;
- a quiet tick either loads the previous data or holds the previous output;
- clear overrides set;
- reset forces its value;
- plain mode is a one-tick delay.

Other behaviour is shown only by the bench scenarios, which run four differently configured instances against a behavioural model:

- the exact initial values;
- falling-edge and active-low variants;
- the one-tick stretch after a control is released;
- the same-tick response of `q` when a control asserts.

// File: rtl/ffemu_pkg.sv
// Shared configuration types for the flip-flop emulator.
package ffemu_pkg;

    // How the emulated element stores its value.
    typedef enum logic [1:0] {
        STORE_PLAIN = 2'd0,   // plain register on the global clock
        STORE_EDGE  = 2'd1,   // edge-triggered on the sampled user clock
        STORE_LATCH = 2'd2    // level-sensitive latch on the enable
    } store_mode_e;

    // Which asynchronous controls overlay the stored value.
    typedef enum logic [1:0] {
        ASYNC_NONE   = 2'd0,
        ASYNC_RESET  = 2'd1,
        ASYNC_SETCLR = 2'd2
    } async_kind_e;

endpackage

// File: rtl/ffemu_clk_edge.sv
// Finds active edges of a user clock sampled on the global clock.
// Assumes uclk is synchronous to gclk. The delayed copy starts at the
// active level, so no edge is reported in the first tick after reset.
module ffemu_clk_edge #(
    parameter bit POL = 1'b1
) (
    input  logic gclk,
    input  logic rst_n,
    input  logic uclk,
    output logic edge_o
);

    logic past_clk;
    logic chk_armed;

    // Keep the previous-tick sample of the user clock.
    always_ff @(posedge gclk) begin
        if (!rst_n) past_clk <= POL;
        else        past_clk <= uclk;
    end

    // Select the (previous, current) pattern that counts as active.
    generate
        if (POL) begin : g_rise
            assign edge_o = ~past_clk & uclk;
        end else begin : g_fall
            assign edge_o = past_clk & ~uclk;
        end
    endgenerate

    // Mark ticks whose $past values were sampled after reset.
    always_ff @(posedge gclk) begin
        if (!rst_n) chk_armed <= 1'b0;
        else        chk_armed <= 1'b1;
    end

    AST_EDGE_IS_CHANGE: assert property (@(posedge gclk) disable iff (!rst_n || !chk_armed)
        edge_o |-> (uclk == POL) && (uclk != $past(uclk)))
        else $error("edge without matching uclk change"); // R2

endmodule

// File: rtl/ffemu_widen.sv
// Stretches asynchronous controls by one global tick and normalises
// them to active high. Assumes ctl_i is synchronous to gclk.
module ffemu_widen #(
    parameter int WIDTH = 1,
    parameter bit POL   = 1'b1
) (
    input  logic             gclk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] ctl_i,
    output logic [WIDTH-1:0] act_o
);

    localparam logic [WIDTH-1:0] IDLE = POL ? '0 : '1;

    logic [WIDTH-1:0] past_ctl;
    logic             chk_armed;

    // Hold the previous-tick control sample, starting inactive.
    always_ff @(posedge gclk) begin
        if (!rst_n) past_ctl <= IDLE;
        else        past_ctl <= ctl_i;
    end

    // Combine current and delayed samples into an active-high result.
    generate
        if (POL) begin : g_high
            assign act_o = ctl_i | past_ctl;
        end else begin : g_low
            assign act_o = ~(ctl_i & past_ctl);
        end
    endgenerate

    // Mark ticks whose $past values were sampled after reset.
    always_ff @(posedge gclk) begin
        if (!rst_n) chk_armed <= 1'b0;
        else        chk_armed <= 1'b1;
    end

    AST_STRETCH_COVERS: assert property (@(posedge gclk) disable iff (!rst_n || !chk_armed)
        (((POL ? $past(ctl_i) : ~$past(ctl_i)) & ~act_o) == '0))
        else $error("stretched control dropped a previous assertion"); // R5

endmodule

// File: rtl/ffemu_hist.sv
// Keeps one-tick-delayed copies of the data input and emulated output.
// Both copies start at the initial value on the synchronous reset.
module ffemu_hist #(
    parameter int               WIDTH    = 8,
    parameter logic [WIDTH-1:0] INIT_VAL = '0
) (
    input  logic             gclk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    input  logic [WIDTH-1:0] q_i,
    output logic [WIDTH-1:0] past_d_o,
    output logic [WIDTH-1:0] past_q_o
);

    // Register data and output history on every global tick.
    always_ff @(posedge gclk) begin
        if (!rst_n) begin
            past_d_o <= INIT_VAL;
            past_q_o <= INIT_VAL;
        end else begin
            past_d_o <= d_i;
            past_q_o <= q_i;
        end
    end

endmodule

// File: rtl/ffemu_top.sv
// Emulates a flip-flop or latch with optional asynchronous controls
// using only registers on the global clock gclk. All inputs, including
// uclk, are assumed synchronous to gclk. q is combinational from the
// history registers and the current controls.
module ffemu_top
    import ffemu_pkg::*;
#(
    parameter int               WIDTH    = 8,
    parameter store_mode_e      MODE     = STORE_EDGE,
    parameter async_kind_e      ASYNC    = ASYNC_SETCLR,
    parameter bit               CLK_POL  = 1'b1,
    parameter bit               EN_POL   = 1'b1,
    parameter bit               ARST_POL = 1'b1,
    parameter bit               SET_POL  = 1'b1,
    parameter bit               CLR_POL  = 1'b1,
    parameter logic [WIDTH-1:0] RST_VAL  = '0,
    parameter logic [WIDTH-1:0] INIT_VAL = '0
) (
    input  logic             gclk,
    input  logic             rst_n,
    input  logic             uclk,
    input  logic [WIDTH-1:0] d,
    input  logic             en,
    input  logic             arst,
    input  logic [WIDTH-1:0] set,
    input  logic [WIDTH-1:0] clr,
    output logic [WIDTH-1:0] q
);

    logic             clk_edge;
    logic             en_w;
    logic             arst_w;
    logic [WIDTH-1:0] set_w;
    logic [WIDTH-1:0] clr_w;
    logic [WIDTH-1:0] past_d;
    logic [WIDTH-1:0] past_q;
    logic [WIDTH-1:0] qval;
    logic             quiet;
    logic             chk_armed;
    logic             unused_sink;

    ffemu_clk_edge #(.POL(CLK_POL)) u_edge (
        .gclk(gclk), .rst_n(rst_n), .uclk(uclk), .edge_o(clk_edge)
    );

    ffemu_widen #(.WIDTH(1), .POL(EN_POL)) u_en_w (
        .gclk(gclk), .rst_n(rst_n), .ctl_i(en), .act_o(en_w)
    );

    ffemu_widen #(.WIDTH(1), .POL(ARST_POL)) u_arst_w (
        .gclk(gclk), .rst_n(rst_n), .ctl_i(arst), .act_o(arst_w)
    );

    ffemu_widen #(.WIDTH(WIDTH), .POL(SET_POL)) u_set_w (
        .gclk(gclk), .rst_n(rst_n), .ctl_i(set), .act_o(set_w)
    );

    ffemu_widen #(.WIDTH(WIDTH), .POL(CLR_POL)) u_clr_w (
        .gclk(gclk), .rst_n(rst_n), .ctl_i(clr), .act_o(clr_w)
    );

    ffemu_hist #(.WIDTH(WIDTH), .INIT_VAL(INIT_VAL)) u_hist (
        .gclk(gclk), .rst_n(rst_n), .d_i(d), .q_i(q),
        .past_d_o(past_d), .past_q_o(past_q)
    );

    // Signals that a given configuration leaves unused are gathered here.
    assign unused_sink = ^{clk_edge, en_w, arst_w, set_w, clr_w, past_d, past_q, qval, quiet};

    // Mark ticks whose $past values were sampled after reset.
    always_ff @(posedge gclk) begin
        if (!rst_n) chk_armed <= 1'b0;
        else        chk_armed <= 1'b1;
    end

    // Pick the stored value for the selected storage style.
    generate
        if (MODE == STORE_EDGE) begin : g_edge
            assign qval = clk_edge ? past_d : past_q;
        end else if (MODE == STORE_LATCH) begin : g_latch
            assign qval = en_w ? d : past_q;
        end else begin : g_plain
            assign qval = past_d;
        end
    endgenerate

    // Overlay the stretched asynchronous controls and drive the output.
    generate
        if (ASYNC == ASYNC_SETCLR) begin : g_sc
            assign quiet = (set_w == '0) && (clr_w == '0);
        end else if (ASYNC == ASYNC_RESET) begin : g_rs
            assign quiet = ~arst_w;
        end else begin : g_na
            assign quiet = 1'b1;
        end

        if (MODE == STORE_PLAIN) begin : g_out_plain
            assign q = qval;
        end else if (ASYNC == ASYNC_SETCLR) begin : g_out_sc
            assign q = (qval | set_w) & ~clr_w;
        end else if (ASYNC == ASYNC_RESET) begin : g_out_rs
            assign q = arst_w ? RST_VAL : qval;
        end else begin : g_out_na
            assign q = qval;
        end
    endgenerate

    // Properties tied to the selected configuration.
    generate
        if (MODE == STORE_EDGE) begin : g_chk_edge
            AST_EDGE_LOADS_DATA: assert property (@(posedge gclk) disable iff (!rst_n || !chk_armed)
                (clk_edge && quiet) |-> (q == $past(d)))
                else $error("edge did not load previous data"); // R3
            AST_NO_EDGE_HOLDS: assert property (@(posedge gclk) disable iff (!rst_n || !chk_armed)
                (!clk_edge && quiet) |-> (q == $past(q)))
                else $error("output changed without an edge"); // R3
        end
        if (MODE == STORE_LATCH) begin : g_chk_latch
            AST_LATCH_FOLLOWS: assert property (@(posedge gclk) disable iff (!rst_n || !chk_armed)
                ((EN_POL ? en : ~en) && quiet) |-> (q == d))
                else $error("open latch not transparent"); // R4
        end
        if (MODE == STORE_PLAIN) begin : g_chk_plain
            AST_PLAIN_DELAY: assert property (@(posedge gclk) disable iff (!rst_n || !chk_armed)
                q == $past(d))
                else $error("plain mode is not a one-tick delay"); // R8
        end
        if (MODE != STORE_PLAIN && ASYNC == ASYNC_SETCLR) begin : g_chk_sc
            AST_CLEAR_WINS: assert property (@(posedge gclk) disable iff (!rst_n)
                (q & (CLR_POL ? clr : ~clr)) == '0)
                else $error("active clear bit reads 1"); // R6
            AST_SET_FORCES: assert property (@(posedge gclk) disable iff (!rst_n)
                ((SET_POL ? set : ~set) & ~clr_w & ~q) == '0)
                else $error("active set bit reads 0"); // R10
        end
        if (MODE != STORE_PLAIN && ASYNC == ASYNC_RESET) begin : g_chk_rs
            AST_RESET_FORCES: assert property (@(posedge gclk) disable iff (!rst_n)
                (ARST_POL ? arst : ~arst) |-> (q == RST_VAL))
                else $error("active reset did not force value"); // R7
        end
    endgenerate

endmodule

// File: tb/ffemu_top_tb.sv
// Drives four configurations from shared inputs and compares each one,
// on every tick, against a behavioural model kept in the bench.
module ffemu_top_tb;
    import ffemu_pkg::*;

    logic       gclk = 1'b0;
    logic       rst_n = 1'b0;
    logic       uclk = 1'b1;
    logic [7:0] d = 8'h00;
    logic       en = 1'b0;
    logic       arst = 1'b1;
    logic [7:0] set = 8'h00;
    logic [7:0] clr = 8'hFF;
    logic [7:0] q_a, q_b, q_c, q_d;

    int checks = 0;
    int errors = 0;

    always #2 gclk = ~gclk;

    // A: rising edge, set high-active, clear low-active.
    ffemu_top #(.WIDTH(8), .MODE(STORE_EDGE), .ASYNC(ASYNC_SETCLR), .CLK_POL(1'b1),
                .SET_POL(1'b1), .CLR_POL(1'b0), .INIT_VAL(8'hA5)) u_dut (
        .gclk(gclk), .rst_n(rst_n), .uclk(uclk), .d(d), .en(en), .arst(arst),
        .set(set), .clr(clr), .q(q_a));
    // B: falling edge, low-active reset.
    ffemu_top #(.WIDTH(8), .MODE(STORE_EDGE), .ASYNC(ASYNC_RESET), .CLK_POL(1'b0),
                .ARST_POL(1'b0), .RST_VAL(8'h3C), .INIT_VAL(8'h00)) u_dut_b (
        .gclk(gclk), .rst_n(rst_n), .uclk(uclk), .d(d), .en(en), .arst(arst),
        .set(set), .clr(clr), .q(q_b));
    // C: latch, high-active enable.
    ffemu_top #(.WIDTH(8), .MODE(STORE_LATCH), .ASYNC(ASYNC_NONE), .EN_POL(1'b1),
                .INIT_VAL(8'h11)) u_dut_c (
        .gclk(gclk), .rst_n(rst_n), .uclk(uclk), .d(d), .en(en), .arst(arst),
        .set(set), .clr(clr), .q(q_c));
    // D: plain register, controls connected but ignored.
    ffemu_top #(.WIDTH(8), .MODE(STORE_PLAIN), .ASYNC(ASYNC_RESET), .ARST_POL(1'b0),
                .RST_VAL(8'hFF), .INIT_VAL(8'h00)) u_dut_d (
        .gclk(gclk), .rst_n(rst_n), .uclk(uclk), .d(d), .en(en), .arst(arst),
        .set(set), .clr(clr), .q(q_d));

    // Behavioural model state.
    logic       m_clk_a, m_clk_b, m_en, m_arst;
    logic [7:0] m_set, m_clr;
    logic [7:0] m_da, m_db, m_dc, m_dd, m_qa, m_qb, m_qc, m_qd;
    logic [7:0] e_a, e_b, e_c, e_d;

    task automatic check(string tag, string name, logic [7:0] got, logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: got %h expected %h", tag, name, got, exp);
        end
    endtask

    task automatic step(string tag);
        logic [7:0] v;
        #1;
        // A: rising edge from (0,1); set ORed, then active-low clear removes bits.
        v   = (!m_clk_a && uclk) ? m_da : m_qa;
        e_a = (v | (set | m_set)) & (clr & m_clr);
        // B: falling edge from (1,0); active-low reset stretched one tick.
        v   = (m_clk_b && !uclk) ? m_db : m_qb;
        e_b = (!arst || !m_arst) ? 8'h3C : v;
        // C: latch transparent while enable now or last tick.
        e_c = (en || m_en) ? d : m_qc;
        // D: data one tick late.
        e_d = m_dd;
        if (rst_n) begin
            check(tag, "A", q_a, e_a);
            check(tag, "B", q_b, e_b);
            check(tag, "C", q_c, e_c);
            check(tag, "D", q_d, e_d);
        end
        @(posedge gclk);
        if (!rst_n) begin
            m_clk_a = 1'b1; m_clk_b = 1'b0; m_en = 1'b0; m_arst = 1'b1;
            m_set = 8'h00; m_clr = 8'hFF;
            m_da = 8'hA5; m_qa = 8'hA5; m_db = 8'h00; m_qb = 8'h00;
            m_dc = 8'h11; m_qc = 8'h11; m_dd = 8'h00; m_qd = 8'h00;
        end else begin
            m_clk_a = uclk; m_clk_b = uclk; m_en = en; m_arst = arst;
            m_set = set; m_clr = clr;
            m_da = d; m_db = d; m_dc = d; m_dd = d;
            m_qa = e_a; m_qb = e_b; m_qc = e_c; m_qd = e_d;
        end
        @(negedge gclk);
    endtask

    // Watchdog: a hung run is a failed check.
    initial begin
        #400000;
        errors++;
        checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        @(negedge gclk);
        repeat (3) step("reset");
        rst_n = 1'b1;
        // R1: initial values visible after reset.
        step("R1");
        step("R1");
        // R2 and R3: user clock toggles with changing data.
        for (int i = 0; i < 6; i++) begin
            d = 8'h13 + 8'(i * 8'h21);
            uclk = ~uclk;
            step("R2");
            d = d ^ 8'hF0;
            step("R3");
        end
        // R3: data changes without a clock edge must be held off.
        d = 8'h77; step("R3");
        d = 8'h88; step("R3");
        // R4: latch enable pulse and its stretched tail.
        en = 1'b1; d = 8'h42; step("R4");
        d = 8'h43; step("R4");
        en = 1'b0; d = 8'h44; step("R4");
        d = 8'h45; step("R4");
        d = 8'h46; step("R4");
        // R10 and R6: set asserts, then an overlapping low-active clear.
        set = 8'h0F; step("R10");
        clr = 8'hF3; step("R6");
        uclk = ~uclk; step("R6");
        uclk = ~uclk; step("R6");
        // R5: release set and clear; effect lasts one more tick.
        set = 8'h00; clr = 8'hFF; step("R5");
        step("R5");
        step("R5");
        // R7 and R9: low-active reset while the clock keeps toggling.
        arst = 1'b0; step("R7");
        uclk = ~uclk; d = 8'h5E; step("R7");
        uclk = ~uclk; step("R9");
        arst = 1'b1; step("R5");
        step("R9");
        // R8: plain mode ignores clock and controls; more traffic.
        for (int i = 0; i < 8; i++) begin
            d = 8'(i * 8'h37);
            en = i[0];
            set = (i == 3) ? 8'h81 : 8'h00;
            arst = (i == 5) ? 1'b0 : 1'b1;
            if (i[1]) uclk = ~uclk;
            step("R8");
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule